// File: doc/BRIEF.md
# Sliding-Window Pixel Fetch Sequencer

This block walks a square grayscale frame held in a byte-addressed memory and gathers the pixels a 3x3 neighbourhood filter needs. It issues one column of three vertically adjacent pixels per step. A four-state loop reads the top, middle and bottom pixel of the current column in three consecutive cycles, then spends a fourth cycle shifting that column into a 3x3 window register. It signals the downstream arithmetic stage when the window holds a complete neighbourhood.

The read address is the concatenation of a line byte and a position byte. Three independent line counters, one per window row, feed a multiplexer that picks the upper address field. A single position counter, shared by all three rows, supplies the lower field. When a traversal along a line finishes, all three line counters move down by one line and the window is wiped. The next line's output then waits for three fresh columns. After the last line triple the block reports completion and returns to idle. The memory answers one clock after each read strobe.

Top module: `wfs_fetch_seq`

## Requirements
- R1: `rd_addr` is the selected line counter times 2^COORD_W plus the position counter: bits [2*COORD_W-1:COORD_W] carry the line and bits [COORD_W-1:0] carry the position.
- R2: A `start` pulse seen while idle loads the line counters with 0, 1 and 2 and the position with 0. Each step then reads line top, top+1 and top+2 at the same position in three consecutive cycles with `rd_en` high, followed by one cycle with `rd_en` low.
- R3: `col_ld` is at most one-hot. Bit k is high exactly in the cycle after the read of window row k (k=0 top), because read data arrive one clock after the strobe.
- R4: The position increments by one per step. After the step at the last position it wraps to 0 and all three line counters increment by one.
- R5: `win_clear` is a one-cycle pulse in the first read cycle of every line traversal, including the first one of a frame. In the next cycle every window element reads zero.
- R6: While `compute_en` is high, window element (r, c) at bits [(3r+c)*PIX_W +: PIX_W] holds the pixel of line top+r at position p-2+c. Here top and p are the line and position of the column shifted in last.
- R7: `compute_en` is a one-cycle pulse in the cycle after each column shift. It is raised only when at least three columns have been shifted in since the last clear, so positions 0 and 1 of every line raise no pulse.
- R8: After the column at the last position of the last line triple (top line 2^COORD_W-3), `done` pulses once together with the final `compute_en`. The block then stays idle with `rd_en` low.
- R9: `start` has no effect while a frame is in progress.
- R10: While reset is active, and in the first cycles after it, `rd_en`, `col_ld`, `win_clear`, `compute_en`, `done` and the whole window are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a frame traversal (only honoured when idle) |
| rd_addr | output | 2*COORD_W | Memory read address {line, position} |
| rd_en | output | 1 | Read strobe, data expected one clock later |
| rd_data | input | PIX_W | Pixel returned by memory |
| col_ld | output | 3 | Load strobes for the top, middle and bottom column registers |
| win_clear | output | 1 | Window wipe pulse at the start of each line traversal |
| compute_en | output | 1 | Window holds a full 3x3 neighbourhood this cycle |
| done | output | 1 | Frame traversal finished |
| win_px | output | 9*PIX_W | Flattened 3x3 window, element 3r+c |

## Verification
A reduced 8x8 frame is swept twice with a memory whose pixel values vary with the address. A per-cycle model of the address, strobes and window then separates wrong line selection, off-by-one data capture and wrong wrap behaviour. A table of hand-worked cycles pins the first step, the first line wrap, the last step and the done cycle. A stray `start` inside the second frame must leave the sequence intact. A reset in the middle of a frame, followed by a full restart, shows that the counters reload cleanly.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  localparam int WIN_N = 3;
  localparam int SEL_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_TOP,
    ST_RD_MID,
    ST_RD_BOT,
    ST_SHIFT
  } seq_state_t;
endpackage

// File: rtl/wfs_seq_ctrl.sv
module wfs_seq_ctrl
  import wfs_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  last_triple,
  output logic [COORD_W-1:0]    pos,
  output logic [SEL_W-1:0]      line_sel,
  output logic                  rd_en,
  output logic                  line_init,
  output logic                  line_adv,
  output logic [WIN_N-1:0]      col_ld,
  output logic                  win_clear,
  output logic                  done
);
  localparam logic [COORD_W-1:0] POS_LAST = '1;

  seq_state_t         st_q, st_n;
  logic [COORD_W-1:0] pos_q, pos_n;
  logic               pos_en;
  logic               clr_q, clr_n;
  logic               done_q, done_n;

  // next-state logic
  always_comb begin
    st_n      = st_q;
    pos_n     = pos_q;
    pos_en    = 1'b0;
    clr_n     = 1'b0;
    done_n    = 1'b0;
    line_init = 1'b0;
    line_adv  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n      = ST_RD_TOP;
          pos_n     = '0;
          pos_en    = 1'b1;
          clr_n     = 1'b1;
          line_init = 1'b1;
        end
      end
      ST_RD_TOP: st_n = ST_RD_MID;
      ST_RD_MID: st_n = ST_RD_BOT;
      ST_RD_BOT: st_n = ST_SHIFT;
      ST_SHIFT: begin
        pos_n  = pos_q + 1'b1;
        pos_en = 1'b1;
        if (pos_q == POS_LAST) begin
          if (last_triple) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else begin
            st_n     = ST_RD_TOP;
            clr_n    = 1'b1;
            line_adv = 1'b1;
          end
        end else begin
          st_n = ST_RD_TOP;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      clr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      clr_q  <= clr_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_n;
    end
  end

  // output decode
  always_comb begin
    rd_en    = 1'b0;
    line_sel = '0;
    col_ld   = '0;
    unique case (st_q)
      ST_RD_TOP: begin
        rd_en    = 1'b1;
        line_sel = SEL_W'(0);
      end
      ST_RD_MID: begin
        rd_en     = 1'b1;
        line_sel  = SEL_W'(1);
        col_ld[0] = 1'b1;
      end
      ST_RD_BOT: begin
        rd_en     = 1'b1;
        line_sel  = SEL_W'(2);
        col_ld[1] = 1'b1;
      end
      ST_SHIFT:  col_ld[2] = 1'b1;
      default:   rd_en = 1'b0;
    endcase
  end

  assign pos       = pos_q;
  assign win_clear = clr_q;
  assign done      = done_q;
endmodule

// File: rtl/wfs_line_ptrs.sv
module wfs_line_ptrs
  import wfs_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               adv,
  input  logic [SEL_W-1:0]   sel,
  output logic [COORD_W-1:0] line_hi,
  output logic               last_triple
);
  logic [COORD_W-1:0] ln_q [WIN_N];

  for (genvar g = 0; g < WIN_N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ln_q[g] <= '0;
      end else if (init) begin
        ln_q[g] <= COORD_W'(g);
      end else if (adv) begin
        ln_q[g] <= ln_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    line_hi = '0;
    for (int k = 0; k < WIN_N; k++) begin
      if (sel == SEL_W'(k)) line_hi = ln_q[k];
    end
  end

  assign last_triple = (ln_q[WIN_N-1] == '1);
endmodule

// File: rtl/wfs_window.sv
module wfs_window
  import wfs_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic [WIN_N-1:0]             ld,
  input  logic [PIX_W-1:0]             rd_data,
  output logic [WIN_N*WIN_N*PIX_W-1:0] win_flat,
  output logic                         compute_en
);
  localparam int CNT_W = $clog2(WIN_N + 1);

  logic [PIX_W-1:0] col_q  [WIN_N-1];
  logic [PIX_W-1:0] newcol [WIN_N];
  logic [PIX_W-1:0] win_q  [WIN_N][WIN_N];
  logic [CNT_W-1:0] cnt_q;
  logic             cmp_q;
  logic             shift;

  assign shift = ld[WIN_N-1];

  for (genvar r = 0; r < WIN_N - 1; r++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        col_q[r] <= '0;
      end else if (clear) begin
        col_q[r] <= '0;
      end else if (ld[r]) begin
        col_q[r] <= rd_data;
      end
    end
    assign newcol[r] = col_q[r];
  end
  assign newcol[WIN_N-1] = rd_data;

  for (genvar r = 0; r < WIN_N; r++) begin : g_row
    for (genvar c = 0; c < WIN_N; c++) begin : g_el
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          win_q[r][c] <= '0;
        end else if (clear) begin
          win_q[r][c] <= '0;
        end else if (shift) begin
          if (c == WIN_N - 1) win_q[r][c] <= newcol[r];
          else                win_q[r][c] <= win_q[r][(c+1)%WIN_N];
        end
      end
      assign win_flat[(r*WIN_N+c)*PIX_W +: PIX_W] = win_q[r][c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (shift && (cnt_q < CNT_W'(WIN_N))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
    end else begin
      cmp_q <= shift && (cnt_q >= CNT_W'(WIN_N - 1));
    end
  end

  assign compute_en = cmp_q;
endmodule

// File: rtl/wfs_fetch_seq.sv
module wfs_fetch_seq
  import wfs_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int PIX_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic [2*COORD_W-1:0]         rd_addr,
  output logic                         rd_en,
  input  logic [PIX_W-1:0]             rd_data,
  output logic [WIN_N-1:0]             col_ld,
  output logic                         win_clear,
  output logic                         compute_en,
  output logic                         done,
  output logic [WIN_N*WIN_N*PIX_W-1:0] win_px
);
  logic               rst_s1, rst_s2;
  logic [COORD_W-1:0] pos;
  logic [COORD_W-1:0] line_hi;
  logic [SEL_W-1:0]   line_sel;
  logic               line_init, line_adv, last_triple;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  wfs_seq_ctrl #(.COORD_W(COORD_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s2),
    .start      (start),
    .last_triple(last_triple),
    .pos        (pos),
    .line_sel   (line_sel),
    .rd_en      (rd_en),
    .line_init  (line_init),
    .line_adv   (line_adv),
    .col_ld     (col_ld),
    .win_clear  (win_clear),
    .done       (done)
  );

  wfs_line_ptrs #(.COORD_W(COORD_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_s2),
    .init       (line_init),
    .adv        (line_adv),
    .sel        (line_sel),
    .line_hi    (line_hi),
    .last_triple(last_triple)
  );

  wfs_window #(.PIX_W(PIX_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_s2),
    .clear     (win_clear),
    .ld        (col_ld),
    .rd_data   (rd_data),
    .win_flat  (win_px),
    .compute_en(compute_en)
  );

  assign rd_addr = {line_hi, pos};
endmodule

// File: rtl/wfs_checker.sv
module wfs_checker #(
  parameter int COORD_W = 8,
  parameter int PIX_W   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2*COORD_W-1:0] rd_addr,
  input logic                 rd_en,
  input logic [2:0]           col_ld,
  input logic                 win_clear,
  input logic                 compute_en,
  input logic                 done,
  input logic [9*PIX_W-1:0]   win_px
);
  localparam int AW = 2 * COORD_W;

  AST_LD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_ld)); // R3

  AST_LD_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ld != 3'b000) |-> $past(rd_en)); // R3

  AST_LINE_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |->
      ((rd_addr[AW-1:COORD_W] == COORD_W'($past(rd_addr[AW-1:COORD_W]) + 1'b1)) &&
       (rd_addr[COORD_W-1:0] == $past(rd_addr[COORD_W-1:0])))); // R1

  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    win_clear |=> !win_clear); // R5

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_clear |=> (win_px == '0)); // R5

  AST_CMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    compute_en |=> !compute_en); // R7

  AST_CMP_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    compute_en |-> $past(col_ld[2])); // R7

  AST_DONE_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (compute_en && !rd_en)); // R8
endmodule

bind wfs_fetch_seq wfs_checker #(.COORD_W(COORD_W), .PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_addr   (rd_addr),
  .rd_en     (rd_en),
  .col_ld    (col_ld),
  .win_clear (win_clear),
  .compute_en(compute_en),
  .done      (done),
  .win_px    (win_px)
);

// File: tb/sim_wfs_fetch_seq.sv
module sim_wfs_fetch_seq;
  localparam int LW = 3;
  localparam int N  = 1 << LW;
  localparam int AW = 2 * LW;
  localparam int PW = 8;
  localparam int STEPS = (N - 2) * N;
  localparam int LAST_C = 4 * STEPS + 1;

  // cycle, rd_en, addr, col_ld, win_clear, compute_en, done
  typedef struct packed {
    logic [8:0] cyc;
    logic       rd;
    logic [5:0] addr;
    logic [2:0] ld;
    logic       clr;
    logic       cmp;
    logic       dn;
  } vec_t;

  localparam vec_t VTAB [13] = '{
    '{9'd1,   1'b1, 6'd0,  3'b000, 1'b1, 1'b0, 1'b0},
    '{9'd2,   1'b1, 6'd8,  3'b001, 1'b0, 1'b0, 1'b0},
    '{9'd3,   1'b1, 6'd16, 3'b010, 1'b0, 1'b0, 1'b0},
    '{9'd4,   1'b0, 6'd0,  3'b100, 1'b0, 1'b0, 1'b0},
    '{9'd9,   1'b1, 6'd2,  3'b000, 1'b0, 1'b0, 1'b0},
    '{9'd13,  1'b1, 6'd3,  3'b000, 1'b0, 1'b1, 1'b0},
    '{9'd33,  1'b1, 6'd8,  3'b000, 1'b1, 1'b1, 1'b0},
    '{9'd34,  1'b1, 6'd16, 3'b001, 1'b0, 1'b0, 1'b0},
    '{9'd35,  1'b1, 6'd24, 3'b010, 1'b0, 1'b0, 1'b0},
    '{9'd37,  1'b1, 6'd9,  3'b000, 1'b0, 1'b0, 1'b0},
    '{9'd189, 1'b1, 6'd47, 3'b000, 1'b0, 1'b1, 1'b0},
    '{9'd191, 1'b1, 6'd63, 3'b010, 1'b0, 1'b0, 1'b0},
    '{9'd193, 1'b0, 6'd0,  3'b000, 1'b0, 1'b1, 1'b1}
  };

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] rd_addr;
  logic          rd_en;
  logic [PW-1:0] rd_data;
  logic [2:0]    col_ld;
  logic          win_clear;
  logic          compute_en;
  logic          done;
  logic [9*PW-1:0] win_px;

  int checks = 0;
  int fails  = 0;

  wfs_fetch_seq #(.COORD_W(LW), .PIX_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data),
    .col_ld(col_ld), .win_clear(win_clear), .compute_en(compute_en),
    .done(done), .win_px(win_px)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [PW-1:0] pix(int a);
    return PW'((a * 29 + 7) % 251 + 1);
  endfunction

  // memory with one clock read latency
  always @(posedge clk) begin
    if (rd_en) rd_data <= pix(int'(rd_addr));
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle model check for cycle c of a frame
  task automatic model_check(int c);
    int ph, s, p, t, sp, tp, pp;
    logic exp_rd, exp_clr, exp_cmp, exp_dn;
    logic [2:0] exp_ld;
    ph = (c - 1) % 4; s = (c - 1) / 4; p = s % N; t = s / N;
    if (c < LAST_C) begin
      exp_rd  = (ph != 3);
      exp_ld  = (ph == 0) ? 3'b000 : 3'(1 << (ph - 1));
      exp_clr = (ph == 0) && (p == 0);
      exp_cmp = (ph == 0) && (s >= 1) && (((s - 1) % N) >= 2);
      exp_dn  = 1'b0;
    end else if (c == LAST_C) begin
      exp_rd = 0; exp_ld = 0; exp_clr = 0; exp_cmp = 1; exp_dn = 1;
    end else begin
      exp_rd = 0; exp_ld = 0; exp_clr = 0; exp_cmp = 0; exp_dn = 0;
    end
    chk(rd_en == exp_rd, "R2", "rd_en", rd_en, exp_rd);
    chk(col_ld == exp_ld, "R3", "col_ld", col_ld, exp_ld);
    chk(win_clear == exp_clr, "R5", "win_clear", win_clear, exp_clr);
    chk(compute_en == exp_cmp, "R7", "compute_en", compute_en, exp_cmp);
    chk(done == exp_dn, "R8", "done", done, exp_dn);
    if (exp_rd) begin
      // R1 R4: address = (top + row) * N + position
      chk(int'(rd_addr) == (t + ph) * N + p, "R1", "rd_addr", rd_addr, (t + ph) * N + p);
    end
    if (c < LAST_C && ph == 1 && p == 0) begin
      chk(win_px == '0, "R5", "window after clear", win_px[63:0], 0);
    end
    if (exp_cmp) begin
      sp = s - 1; tp = sp / N; pp = sp % N;
      for (int r = 0; r < 3; r++) begin
        for (int cc = 0; cc < 3; cc++) begin
          chk(win_px[(r*3+cc)*PW +: PW] == pix((tp + r) * N + pp - 2 + cc), "R6",
              "window element", win_px[(r*3+cc)*PW +: PW], pix((tp + r) * N + pp - 2 + cc));
        end
      end
    end
  endtask

  // one frame: start, then check every cycle; optional stray start at cycle stray_c
  task automatic run_frame(int stray_c, bit use_table);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 1; c <= LAST_C + 2; c++) begin
      if (c > 1) @(negedge clk);
      start = (c == stray_c);
      model_check(c);
      if (use_table) begin
        for (int i = 0; i < 13; i++) begin
          if (int'(VTAB[i].cyc) == c) begin
            chk(rd_en == VTAB[i].rd, "R2", "table rd_en", rd_en, VTAB[i].rd);
            if (VTAB[i].rd) chk(rd_addr == VTAB[i].addr, "R1", "table rd_addr", rd_addr, VTAB[i].addr);
            chk(col_ld == VTAB[i].ld, "R3", "table col_ld", col_ld, VTAB[i].ld);
            chk(win_clear == VTAB[i].clr, "R5", "table win_clear", win_clear, VTAB[i].clr);
            chk(compute_en == VTAB[i].cmp, "R7", "table compute_en", compute_en, VTAB[i].cmp);
            chk(done == VTAB[i].dn, "R8", "table done", done, VTAB[i].dn);
          end
        end
      end
    end
    start = 1'b0;
  endtask

  task automatic idle_check(string req);
    chk(rd_en == 1'b0, req, "rd_en idle", rd_en, 0);
    chk(col_ld == 3'b000, req, "col_ld idle", col_ld, 0);
    chk(win_clear == 1'b0, req, "win_clear idle", win_clear, 0);
    chk(compute_en == 1'b0, req, "compute_en idle", compute_en, 0);
    chk(done == 1'b0, req, "done idle", done, 0);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    idle_check("R10");
    chk(win_px == '0, "R10", "window in reset", win_px[63:0], 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("R10");

    // frame 1: table walk plus full model
    run_frame(0, 1'b1);
    // R8: stays idle after done
    repeat (5) @(negedge clk);
    idle_check("R8");

    // frame 2: stray start mid-frame must be ignored (R9)
    run_frame(50, 1'b0);

    // reset in the middle of a frame, then a clean restart (R10, R2)
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (70) @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_check("R10");
    chk(win_px == '0, "R10", "window after mid-frame reset", win_px[63:0], 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_frame(0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule